// File: doc/BRIEF.md
# Sample Fetch Stall Arbiter

When the audio sample channel needs one byte from memory, the processor has to give up the bus for a few cycles. The number of stolen cycles depends on what the bus is doing when the request strobe arrives. The bus may be idle or reading. It may be in a CPU write cycle, and that write may target the sprite-DMA trigger address. A sprite copy may already be running, and then the number of bytes it still has to move also matters. This block classifies that context in the request cycle and loads the matching stall length. It then counts the stall down, one step per CPU cycle.

While the stall runs, `stall_o` is high. The surrounding core uses it both to hold the processor and to freeze interrupt-line sampling. When the count reaches zero, the stall ends and a one-cycle `buf_load_o` pulse tells the sample channel to take its fetched byte into its read buffer. A strobe that arrives while a stall is in progress is dropped. The block has no data path, so every pin is a plain control or status signal and no handshake applies.

Top module: `smp_stall_arb`

## Requirements
- R1: A request accepted with `spr_dma_act_i` low and `cpu_wr_i` low starts a stall of 4 cycles.
- R2: A request accepted with `spr_dma_act_i` low, `cpu_wr_i` high and `wr_addr_i` equal to 0x4014 starts a stall of 2 cycles.
- R3: A request accepted with `spr_dma_act_i` low, `cpu_wr_i` high and any other `wr_addr_i` starts a stall of 3 cycles.
- R4: A request accepted with `spr_dma_act_i` high starts a stall of 1 cycle when `spr_dma_left_i` is 2, and of 3 cycles when it is 1.
- R5: A request accepted with `spr_dma_act_i` high and any other `spr_dma_left_i` value (including 0 and 256) starts a stall of 2 cycles, whatever `cpu_wr_i` and `wr_addr_i` are.
- R6: A stall of N cycles drives `stall_o` high for exactly N consecutive cycles, starting in the cycle after the clock edge that sampled the request. During those cycles `stall_cnt_o` shows N, N-1, ... down to 1. The core freezes interrupt polling for the whole time `stall_o` is high.
- R7: In the cycle right after the last stall cycle, `stall_cnt_o` is 0, `stall_o` is low and `buf_load_o` is high. `buf_load_o` is high for that one cycle only.
- R8: A request sampled while `stall_o` is high, including during the last stall cycle, is ignored: the countdown goes on unchanged and no second stall follows. A request in the `buf_load_o` cycle is accepted.
- R9: While `rst_n` is low, and after it rises, `stall_o`, `buf_load_o` and `stall_cnt_o` are 0 until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Sample-fetch request strobe |
| cpu_wr_i | input | 1 | The current CPU cycle is a write |
| wr_addr_i | input | 16 | Address of the current CPU write |
| spr_dma_act_i | input | 1 | A sprite copy is in progress |
| spr_dma_left_i | input | 9 | Bytes the sprite copy still has to move |
| stall_o | output | 1 | Processor hold and interrupt-poll freeze |
| stall_cnt_o | output | 3 | Stall cycles remaining |
| buf_load_o | output | 1 | One-cycle load strobe for the sample read buffer |

## Verification
The bench targets three kinds of error.

The first is context classification. A wrong priority, where a write is checked before the sprite flag, turns a 2-cycle stall into a 3-cycle one. Swapping the remaining-count values 1 and 2 swaps the 1- and 3-cycle stalls. A bad address compare treats writes to 0x4015 like writes to 0x4014.

The second is the end of the countdown. An off-by-one stretches or shortens `stall_o`, or moves the load pulse so that it overlaps the last stall cycle. The single-cycle stall is the sharpest test here.

The third is request handling. A design that re-arms on a strobe during the final stall cycle would chain two stalls together. A design that blocks strobes in the load cycle would lose the back-to-back request.

// File: rtl/smp_stall_pkg.sv
package smp_stall_pkg;

  // Bus context seen in the request cycle, in priority order
  typedef enum logic [2:0] {
    CTX_SPR_LAST2 = 3'd0,
    CTX_SPR_LAST1 = 3'd1,
    CTX_SPR_OTHER = 3'd2,
    CTX_WR_TRIG   = 3'd3,
    CTX_WR_OTHER  = 3'd4,
    CTX_READ      = 3'd5
  } bus_ctx_e;

endpackage

// File: rtl/smp_stall_ctx.sv
module smp_stall_ctx
  import smp_stall_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LEFT_W    = 9,
  parameter int CNT_W     = 3,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014,
  parameter int LEN_READ  = 4,
  parameter int LEN_WTRIG = 2,
  parameter int LEN_WOTH  = 3,
  parameter int LEN_SPR2  = 1,
  parameter int LEN_SPR1  = 3,
  parameter int LEN_SPRX  = 2
) (
  input  logic              cpu_wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              spr_dma_act_i,
  input  logic [LEFT_W-1:0] spr_dma_left_i,
  output bus_ctx_e          ctx_o,
  output logic [CNT_W-1:0]  len_o
);

  localparam logic [LEFT_W-1:0] LEFT_ONE = LEFT_W'(1);
  localparam logic [LEFT_W-1:0] LEFT_TWO = LEFT_W'(2);

  always_comb begin
    if (spr_dma_act_i) begin
      if (spr_dma_left_i == LEFT_TWO)      ctx_o = CTX_SPR_LAST2;
      else if (spr_dma_left_i == LEFT_ONE) ctx_o = CTX_SPR_LAST1;
      else                                 ctx_o = CTX_SPR_OTHER;
    end else if (cpu_wr_i) begin
      ctx_o = (wr_addr_i == TRIG_ADDR) ? CTX_WR_TRIG : CTX_WR_OTHER;
    end else begin
      ctx_o = CTX_READ;
    end
  end

  always_comb begin
    unique case (ctx_o)
      CTX_SPR_LAST2: len_o = CNT_W'(LEN_SPR2);
      CTX_SPR_LAST1: len_o = CNT_W'(LEN_SPR1);
      CTX_SPR_OTHER: len_o = CNT_W'(LEN_SPRX);
      CTX_WR_TRIG:   len_o = CNT_W'(LEN_WTRIG);
      CTX_WR_OTHER:  len_o = CNT_W'(LEN_WOTH);
      default:       len_o = CNT_W'(LEN_READ);
    endcase
  end

endmodule

// File: rtl/smp_stall_ctr.sv
module smp_stall_ctr #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      cnt_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (busy_o) begin
        cnt_o <= cnt_o - ONE;
        if (cnt_o == ONE) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end else if (start_i) begin
        cnt_o  <= len_i;
        busy_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/smp_stall_arb.sv
module smp_stall_arb
  import smp_stall_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEFT_W = 9,
  parameter int CNT_W  = 3,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              cpu_wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              spr_dma_act_i,
  input  logic [LEFT_W-1:0] spr_dma_left_i,
  output logic              stall_o,
  output logic [CNT_W-1:0]  stall_cnt_o,
  output logic              buf_load_o
);

  bus_ctx_e         ctx;
  logic [CNT_W-1:0] len;
  logic             accept;

  smp_stall_ctx #(
    .ADDR_W(ADDR_W), .LEFT_W(LEFT_W), .CNT_W(CNT_W), .TRIG_ADDR(TRIG_ADDR)
  ) u_ctx (
    .cpu_wr_i      (cpu_wr_i),
    .wr_addr_i     (wr_addr_i),
    .spr_dma_act_i (spr_dma_act_i),
    .spr_dma_left_i(spr_dma_left_i),
    .ctx_o         (ctx),
    .len_o         (len)
  );

  // Requests while busy are dropped (R8)
  assign accept = req_i && !stall_o;

  smp_stall_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(accept),
    .len_i  (len),
    .busy_o (stall_o),
    .cnt_o  (stall_cnt_o),
    .done_o (buf_load_o)
  );

endmodule

// File: rtl/smp_stall_arb_chk.sv
module smp_stall_arb_chk #(
  parameter int ADDR_W = 16,
  parameter int LEFT_W = 9,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic              cpu_wr_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              spr_dma_act_i,
  input logic [LEFT_W-1:0] spr_dma_left_i,
  input logic              stall_o,
  input logic [CNT_W-1:0]  stall_cnt_o,
  input logic              buf_load_o
);

  p_read_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !stall_o && !spr_dma_act_i && !cpu_wr_i) |=> (stall_o && stall_cnt_o == CNT_W'(4)));

  p_trig_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !stall_o && !spr_dma_act_i && cpu_wr_i && wr_addr_i == 16'h4014)
    |=> (stall_o && stall_cnt_o == CNT_W'(2)));

  p_spr_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !stall_o && spr_dma_act_i && spr_dma_left_i == LEFT_W'(2))
    |=> (stall_o && stall_cnt_o == CNT_W'(1)));

  p_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && stall_cnt_o > CNT_W'(1)) |=> (stall_o && stall_cnt_o == $past(stall_cnt_o) - CNT_W'(1)));

  p_end_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_o) |-> (buf_load_o && stall_cnt_o == '0));

  p_load_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_load_o |=> !buf_load_o);

  p_ignore_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && stall_cnt_o == CNT_W'(1) && req_i) |=> (!stall_o && buf_load_o));

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_o |-> stall_cnt_o == '0);

endmodule

bind smp_stall_arb smp_stall_arb_chk #(
  .ADDR_W(ADDR_W), .LEFT_W(LEFT_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .cpu_wr_i(cpu_wr_i),
  .wr_addr_i(wr_addr_i), .spr_dma_act_i(spr_dma_act_i),
  .spr_dma_left_i(spr_dma_left_i), .stall_o(stall_o),
  .stall_cnt_o(stall_cnt_o), .buf_load_o(buf_load_o)
);

// File: tb/smp_stall_arb_tb.sv
`timescale 1ns/1ps
module smp_stall_arb_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic        cpu_wr_i = 1'b0;
  logic [15:0] wr_addr_i = '0;
  logic        spr_dma_act_i = 1'b0;
  logic [8:0]  spr_dma_left_i = '0;
  logic        stall_o;
  logic [2:0]  stall_cnt_o;
  logic        buf_load_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // reference state
  int    m_cnt  = 0;
  bit    m_act  = 0;
  bit    m_load = 0;
  bit    m_ign  = 0;
  string m_tag  = "R9";

  always #4 clk = ~clk;   // 125 MHz

  smp_stall_arb u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .cpu_wr_i(cpu_wr_i),
    .wr_addr_i(wr_addr_i), .spr_dma_act_i(spr_dma_act_i),
    .spr_dma_left_i(spr_dma_left_i), .stall_o(stall_o),
    .stall_cnt_o(stall_cnt_o), .buf_load_o(buf_load_o)
  );

  function automatic int exp_len(output string tag);
    if (spr_dma_act_i) begin
      if (spr_dma_left_i == 2)      begin tag = "R4"; return 1; end
      else if (spr_dma_left_i == 1) begin tag = "R4"; return 3; end
      tag = "R5"; return 2;
    end
    if (cpu_wr_i) begin
      if (wr_addr_i == 16'h4014) begin tag = "R2"; return 2; end
      tag = "R3"; return 3;
    end
    tag = "R1"; return 4;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_act = 0; m_load = 0; m_ign = 0; m_tag = "R9";
    end else begin
      m_load = 0;
      m_ign  = 0;
      if (m_act) begin
        m_ign = req_i;
        m_cnt--;
        if (m_cnt == 0) begin m_act = 0; m_load = 1; end
      end else if (req_i) begin
        string t;
        m_cnt = exp_len(t);
        m_tag = t;
        m_act = 1;
      end else begin
        m_tag = "R9";
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      string tag;
      tag = m_load ? "R7" : (m_ign ? "R8" : (m_act ? m_tag : "R9"));
      checks++;
      if (stall_o !== m_act || stall_cnt_o !== 3'(m_cnt) || buf_load_o !== m_load) begin
        fails++;
        $display("FAIL %s t=%0t act stall=%b cnt=%0d load=%b exp stall=%b cnt=%0d load=%b",
                 tag, $time, stall_o, stall_cnt_o, buf_load_o, m_act, m_cnt, m_load);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fire(input bit wr, input logic [15:0] addr, input bit spr, input logic [8:0] left);
    @(negedge clk);
    req_i = 1'b1; cpu_wr_i = wr; wr_addr_i = addr; spr_dma_act_i = spr; spr_dma_left_i = left;
    @(negedge clk);
    req_i = 1'b0; cpu_wr_i = 1'b0; wr_addr_i = '0; spr_dma_act_i = 1'b0; spr_dma_left_i = '0;
  endtask

  initial begin
    idle(3);                                  // R9 reset state checked each cycle
    rst_n = 1'b1;
    idle(2);
    fire(0, 16'h0000, 0, 9'd0);   idle(6);    // R1
    fire(1, 16'h4014, 0, 9'd0);   idle(4);    // R2
    fire(1, 16'h4015, 0, 9'd0);   idle(5);    // R3
    fire(1, 16'h0014, 0, 9'd0);   idle(5);    // R3
    fire(0, 16'h0000, 1, 9'd2);   idle(3);    // R4 single-cycle stall
    fire(0, 16'h0000, 1, 9'd1);   idle(5);    // R4
    fire(1, 16'h4014, 1, 9'd0);   idle(4);    // R5 sprite priority
    fire(1, 16'h1234, 1, 9'd256); idle(4);    // R5
    fire(0, 16'h0000, 1, 9'd3);   idle(4);    // R5
    // R8: strobe held through whole stall incl. last cycle, then in load cycle
    @(negedge clk);
    req_i = 1'b1;
    idle(7);
    req_i = 1'b0;
    idle(6);
    // R8: request exactly in the load cycle after a 1-cycle stall
    @(negedge clk);
    req_i = 1'b1; spr_dma_act_i = 1'b1; spr_dma_left_i = 9'd2;
    @(negedge clk);
    spr_dma_act_i = 1'b0; spr_dma_left_i = 9'd0;
    @(negedge clk);
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    idle(8);
    // mixed random contexts
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      req_i          = ($urandom_range(0, 2) == 0);
      cpu_wr_i       = $urandom_range(0, 1);
      wr_addr_i      = ($urandom_range(0, 1) == 0) ? 16'h4014 : 16'(($urandom_range(0, 65535)));
      spr_dma_act_i  = ($urandom_range(0, 2) == 0);
      spr_dma_left_i = 9'($urandom_range(0, 4));
    end
    req_i = 1'b0;
    idle(8);
    // R9: reset mid-stall returns to idle
    fire(0, 16'h0000, 0, 9'd0);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(3);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule